// File: doc/BRIEF.md
# Odd-Parity Digital Output Stage

This block is the last register in front of a 32-bit digital output port. An upstream sequencer presents a 32-bit word with a one-cycle valid strobe. The block loads that word into the port register, but bit 30 of the port carries a bit generated in hardware instead of the supplied one. In the default mode that bit is odd parity. It is 1 XORed with all 32 supplied bits, and the supplied bit 30 is one of those 32 bits. Because the supplied bit 30 counts in the parity, software can get any exact 32-bit pattern on the port. It does this by flipping bit 30 of the word before sending it, whenever the wanted bit 30 differs from the odd parity of the wanted word.

A legacy input selects the older behaviour. In that mode bit 30 acts as a toggling data strobe that inverts on every valid strobe, and the other 31 bits pass straight through. The toggle is held in a two-state machine with states `TGL_LO` and `TGL_HI`. The transition `TGL_LO -> TGL_HI` or `TGL_HI -> TGL_LO` happens only on a strobe in legacy mode. Without such a strobe the machine stays in its current state, which covers strobes in parity mode and idle cycles. Reset forces `TGL_LO`. The port register is updated one clock after the strobe and holds its value otherwise.

Top module: `odd_parity_dio_out`

## Requirements
- R1: While reset is asserted, the port reads 0x00000000 and the toggle state is `TGL_LO`, so the first legacy-mode strobe after reset drives port bit 30 to 1.
- R2: In parity mode (legacy input low), a valid strobe loads the supplied bits 31 and 29..0 onto the same port positions. The port changes at the first rising clock edge that samples the strobe.
- R3: In parity mode, port bit 30 after a strobe equals 1 XOR the XOR of all 32 supplied bits, supplied bit 30 included. For example, word 0x00000000 gives port 0x40000000, 0xFFFFFFFF gives 0xFFFFFFFF, and 0x40000000 gives 0x00000000.
- R4: For any wanted word D, software sends D with bit 30 inverted when D[30] differs from 1 XOR the XOR of all bits of D, and sends D unchanged otherwise. In parity mode the port then shows exactly D.
- R5: In a cycle without a valid strobe, the port keeps its value whatever the word and legacy inputs carry.
- R6: In legacy mode, each valid strobe flips the toggle state, and port bit 30 takes the new state, with `TGL_HI` driving 1 and `TGL_LO` driving 0.
- R7: In legacy mode, a valid strobe loads the supplied bits 31 and 29..0 unchanged.
- R8: Strobes in parity mode and idle cycles leave the toggle state unchanged, so a later legacy strobe continues the sequence that earlier legacy strobes left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| legacy_i | input | 1 | 1 selects the toggling strobe on bit 30, 0 selects odd parity |
| word_vld_i | input | 1 | Valid strobe for word_i |
| word_i | input | 32 | Word from the output sequencer |
| port_o | output | 32 | Registered value driven to the output port |

## Verification
A wrong toggle state does not show up until the next legacy strobe. That strobe then puts the wrong polarity on port bit 30, one clock after it arrives, and every later legacy strobe carries the same error. A fault in the parity tree shows on bit 30 one clock after the parity-mode word that exposes it. The bench therefore mixes dense and sparse bit patterns and runs precompensated words. A wrong load enable shows as a port that changes with no strobe, or that keeps its old value after one, on the very next cycle.

// File: rtl/odd_par_pkg.sv
package odd_par_pkg;

    // Port geometry; the mark position is fixed by the port convention.
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned MARK_POS = 30;

    // Toggle state of the legacy data strobe.
    typedef enum logic [0:0] {
        TGL_LO = 1'b0,
        TGL_HI = 1'b1
    } tgl_state_e;

    // Source of the mark bit for the current strobe.
    typedef enum logic [0:0] {
        MODE_PARITY = 1'b0,
        MODE_LEGACY = 1'b1
    } mark_mode_e;

endpackage

// File: rtl/odd_par_tree.sv
// Balanced XOR tree with an odd seed: odd_o = 1 ^ (XOR of every data bit).
module odd_par_tree #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             odd_o
);
    localparam int unsigned LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int unsigned PAD    = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        logic [(PAD >> l)-1:0] v;
        if (l == 0) begin : g_leaf
            assign v = PAD'(data_i);
        end else begin : g_node
            for (genvar i = 0; i < (PAD >> l); i++) begin : g_xor
                assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
            end
        end
    end

    assign odd_o = ~g_lvl[LEVELS].v[0];

endmodule

// File: rtl/strobe_toggle_fsm.sv
// Two-state machine holding the legacy data-strobe level.
module strobe_toggle_fsm
    import odd_par_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       adv_i,
    output tgl_state_e state_o,
    output logic       mark_o
);
    tgl_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= TGL_LO;
        else         state_q <= state_d;
    end

    // Next state and mark level for a strobe taken this cycle.
    always_comb begin
        state_d = state_q;
        mark_o  = 1'b0;
        unique case (state_q)
            TGL_LO: begin
                mark_o = 1'b1;
                if (adv_i) state_d = TGL_HI;
            end
            TGL_HI: begin
                mark_o = 1'b0;
                if (adv_i) state_d = TGL_LO;
            end
            default: state_d = TGL_LO;
        endcase
    end

    assign state_o = state_q;

    AST_TOGGLE_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> state_q != $past(state_q)); // R6
    AST_TOGGLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(state_q)); // R8

endmodule

// File: rtl/port_out_reg.sv
// Output register of the port: loads on strobe, holds otherwise.
module port_out_reg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(q_o)); // R5

endmodule

// File: rtl/odd_parity_dio_out.sv
module odd_parity_dio_out
    import odd_par_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              legacy_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] port_o
);
    localparam logic [WORD_W-1:0] MARK_MASK = WORD_W'(1) << MARK_POS;

    mark_mode_e        mode;
    tgl_state_e        tgl_state;
    logic              par_bit;
    logic              tgl_bit;
    logic              mark_bit;
    logic [WORD_W-1:0] next_word;

    assign mode = legacy_i ? MODE_LEGACY : MODE_PARITY;

    odd_par_tree #(.WIDTH(WORD_W)) u_tree (
        .data_i (word_i),
        .odd_o  (par_bit)
    );

    strobe_toggle_fsm u_tgl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (word_vld_i && (mode == MODE_LEGACY)),
        .state_o (tgl_state),
        .mark_o  (tgl_bit)
    );

    always_comb begin
        unique case (mode)
            MODE_PARITY: mark_bit = par_bit;
            MODE_LEGACY: mark_bit = tgl_bit;
            default:     mark_bit = par_bit;
        endcase
        next_word           = word_i;
        next_word[MARK_POS] = mark_bit;
    end

    port_out_reg #(.WIDTH(WORD_W)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (word_vld_i),
        .d_i    (next_word),
        .q_o    (port_o)
    );

    AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_vld_i |=> (port_o & ~MARK_MASK) == ($past(word_i) & ~MARK_MASK)); // R2
    AST_ODD_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld_i && !legacy_i) |=> port_o[MARK_POS] == ~^$past(word_i)); // R3
    AST_LEGACY_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld_i && legacy_i) |=> port_o[MARK_POS] == (tgl_state == TGL_HI)); // R6

endmodule

// File: tb/sim_odd_parity_dio_out.sv
`timescale 1ns/1ps
module sim_odd_parity_dio_out;
    localparam int PER = 8;
    localparam logic [31:0] MASK30 = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy = 1'b0;
    logic        vld = 1'b0;
    logic [31:0] word = '0;
    logic [31:0] port;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_port = '0;
    bit          m_tgl = 1'b0;
    logic [31:0] rng = 32'h1234_5679;

    always #(PER/2) clk = ~clk;

    odd_parity_dio_out u0 (
        .clk_i(clk), .rst_ni(rst_n), .legacy_i(legacy),
        .word_vld_i(vld), .word_i(word), .port_o(port)
    );

    function automatic logic odd_of(input logic [31:0] w);
        int ones = 0;
        for (int i = 0; i < 32; i++) ones += int'(w[i]);
        return (ones % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    function automatic logic [31:0] make_raw(input logic [31:0] d);
        return (d[30] == odd_of(d)) ? d : (d ^ MASK30);
    endfunction

    task automatic next_rng();
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic lg, input logic [31:0] w,
                        input string tag_rest, input string tag_mark);
        @(negedge clk);
        vld = v; legacy = lg; word = w;
        @(posedge clk);
        if (v) begin
            m_port = w;
            if (lg) begin
                m_tgl = !m_tgl;
                m_port[30] = m_tgl;
            end else begin
                m_port[30] = odd_of(w);
            end
        end
        #2;
        check(tag_rest, port & ~MASK30, m_port & ~MASK30);
        check(tag_mark, {31'd0, port[30]}, {31'd0, m_port[30]});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vld = 1'b0;
        m_port = '0; m_tgl = 1'b0;
        @(negedge clk);
        check("R1", port, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(PER * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", port, 32'h0);
        rst_n = 1'b1;

        // R5: idle with junk on inputs
        step(1'b0, 1'b0, 32'hDEAD_BEEF, "R5", "R5");
        step(1'b0, 1'b1, 32'h5555_AAAA, "R5", "R5");

        // R1: first legacy strobe after reset drives bit 30 high
        step(1'b1, 1'b1, 32'h0000_0000, "R7", "R6");
        check("R1", port, 32'h4000_0000);

        // R3 boundary words
        step(1'b1, 1'b0, 32'h0000_0000, "R2", "R3");
        check("R3", port, 32'h4000_0000);
        step(1'b1, 1'b0, 32'hFFFF_FFFF, "R2", "R3");
        check("R3", port, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, 32'h4000_0000, "R2", "R3");
        check("R3", port, 32'h0000_0000);

        // R2/R3 random, with R5 idles
        for (int i = 0; i < 30; i++) begin
            next_rng();
            if (i % 3 == 2) step(1'b0, rng[0], rng, "R5", "R5");
            else            step(1'b1, 1'b0, rng, "R2", "R3");
        end
        for (int i = 0; i < 8; i++) begin
            next_rng();
            step(1'b1, 1'b0, rng & (32'h1 << (i * 4)), "R2", "R3");
        end

        // R4: precompensation yields the exact wanted word
        begin
            logic [31:0] want [6] = '{32'h0, 32'h4000_0000, 32'hFFFF_FFFF,
                                      32'h8000_8001, 32'hC012_3456, 32'hBFFF_FFFF};
            foreach (want[k]) begin
                step(1'b1, 1'b0, make_raw(want[k]), "R2", "R3");
                check("R4", port, want[k]);
            end
        end
        for (int i = 0; i < 10; i++) begin
            next_rng();
            step(1'b1, 1'b0, make_raw(rng), "R2", "R3");
            check("R4", port, rng);
        end

        // R6/R7: legacy toggling
        for (int i = 0; i < 6; i++) begin
            next_rng();
            step(1'b1, 1'b1, rng, "R7", "R6");
            if (i % 2 == 1) step(1'b0, 1'b1, ~rng, "R5", "R5");
        end

        // R8: parity strobes between legacy strobes do not disturb the toggle
        for (int j = 0; j < 3; j++) begin
            for (int i = 0; i < 3; i++) begin
                next_rng();
                step(1'b1, 1'b0, rng, "R2", "R3");
            end
            next_rng();
            step(1'b1, 1'b1, rng, "R7", "R8");
        end

        // R1: reset mid-run clears port and toggle
        do_reset();
        step(1'b1, 1'b1, 32'h0000_0000, "R7", "R1");
        check("R1", port, 32'h4000_0000);
        step(1'b1, 1'b1, 32'h0000_0000, "R7", "R6");
        check("R6", port, 32'h0000_0000);

        finish_run();
    end
endmodule